// File: doc/BRIEF.md
# Status Register Write-Protection Controller

This block keeps the eight-bit status byte of a small serial non-volatile memory. It decides, cycle by cycle, whether the status register may be updated and whether a given array byte address may be programmed. A command decoder drives single-cycle pulses into it: set-enable, clear-enable, status-write and array-write. It also drives the level of the write-protect pin, a busy flag from the programming timer, the data byte of a status write and the target address of an array write. The block returns the readable status byte and two permit flags. The non-volatile fields are plain registers with a reset value.

A small state machine tracks one accepted write cycle. In `IDLE` it accepts commands. An accepted status write moves it to `SR_WAIT`, and an accepted array write moves it to `AR_WAIT`. From either wait state, the busy flag rising moves it to `SR_BUSY` or `AR_BUSY`. The busy flag falling then commits the cycle and returns the machine to `IDLE`. A status write that finishes loads the staged protect fields. Either kind of cycle that finishes clears the enable latch. A parameter selects a 1024-byte or a 2048-byte array for the block-protect decode.

Top module: `sr_wprot`

## Requirements
- R1: The status byte is laid out as follows: bit 7 holds the protect-enable flag, bits 6 to 4 always read 1, bits 3:2 hold the block-protect code, bit 1 holds the write-enable latch, and bit 0 holds the ready/busy bit. Bit 0 is 1 while an accepted cycle is pending or running.
- R2: While `busy_i` is high, the status byte reads 8'hFF and neither permit is given.
- R3: Reset clears the write-enable latch, the protect-enable flag and the block-protect code, so the status byte reads 8'h70 and both permits are 0. Reset also abandons a pending cycle.
- R4: An enable-set pulse (`ev_wren_i`) accepted in `IDLE` sets the latch. An enable-clear pulse (`ev_wrdi_i`) clears it. The completion of an accepted status or array write also clears it.
- R5: While the latch is 0, both permits are 0, and status-write and array-write pulses are ignored.
- R6: The block-protect code guards part of the array. Code 00 guards nothing. Code 01 guards the top quarter: 0x600-0x7FF for the large array, or 0x300-0x3FF for the small one. Code 10 guards the top half, from 0x400 or 0x200 upwards. Code 11 guards the whole array.
- R7: An address inside the guarded region never gets the array permit. An array-write pulse aimed at such an address is ignored: no cycle starts and the latch is kept.
- R8: Hardware protection is on when the protect-enable flag is 1 and `wp_n_i` is 0. It withholds the status permit and makes status-write pulses be ignored. It never withholds the array permit.
- R9: A status write stores only data bits 7 and 3:2. The stored values appear only when the cycle completes.
- R10: After acceptance, the machine waits for `busy_i` to rise, then for it to fall. It commits on the edge where it sees `busy_i` low in a busy state. Every command pulse outside `IDLE`, or while `busy_i` is high, is ignored, and both permits are 0 throughout.
- R11: Address bits above the array width do not affect the array permit.

Top module ports are listed below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wp_n_i | input | 1 | Write-protect pin level, low asserts |
| busy_i | input | 1 | Programming timer running |
| ev_wren_i | input | 1 | Enable-set command pulse |
| ev_wrdi_i | input | 1 | Enable-clear command pulse |
| ev_wrsr_i | input | 1 | Status-write command pulse |
| ev_write_i | input | 1 | Array-write command pulse |
| wrsr_data_i | input | 8 | Data byte of a status write |
| addr_i | input | ADDR_W | Array byte address under test |
| status_o | output | 8 | Readable status byte |
| sr_permit_o | output | 1 | Status register update allowed now |
| arr_permit_o | output | 1 | Byte at `addr_i` may be programmed now |

## Verification
The bench targets the boundary addresses of each protect code, for example 0x5FF against 0x600, and 0x3FF against 0x400. A decode that is off by one region would grant or deny the wrong byte there. It also targets a status write issued with the pin low while the protect-enable flag is still 0. A design that protects on the pin alone would refuse that write. Further cases cover command pulses issued during the wait and busy states, a staged status value read back before completion, and aliased upper address bits. Each of these exposes designs that start a second cycle, publish the staged value early, or decode the full address. A second instance built for the small array checks its own quarter boundary.

// File: rtl/wprot_pkg.sv
package wprot_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_SR_WAIT = 3'd1,
        ST_SR_BUSY = 3'd2,
        ST_AR_WAIT = 3'd3,
        ST_AR_BUSY = 3'd4
    } wp_state_e;

    // Status byte bit positions (visible to software readers).
    localparam int SB_PEN  = 7;
    localparam int SB_BPHI = 3;
    localparam int SB_BPLO = 2;
    localparam int SB_WEN  = 1;
    localparam int SB_RDY  = 0;

    typedef struct packed {
        logic       pen;
        logic [1:0] bp;
    } nv_fields_t;

endpackage

// File: rtl/wprot_bp_decode.sv
module wprot_bp_decode #(
    parameter int ADDR_W    = 16,
    parameter bit BIG_ARRAY = 1'b1
) (
    input  logic [1:0]        bp_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              guarded_o
);
    localparam int MEM_AW = BIG_ARRAY ? 11 : 10;

    logic [1:0] top2;

    generate
        if (BIG_ARRAY) begin : g_big
            assign top2 = addr_i[10:9];
        end else begin : g_small
            assign top2 = addr_i[9:8];
        end
    endgenerate

    always_comb begin
        unique case (bp_i)
            2'b00:   guarded_o = 1'b0;
            2'b01:   guarded_o = (top2 == 2'b11);
            2'b10:   guarded_o = top2[1];
            default: guarded_o = 1'b1;
        endcase
    end

    initial begin
        if (ADDR_W < MEM_AW) $error("address narrower than array");
    end
endmodule

// File: rtl/wprot_regs.sv
module wprot_regs
    import wprot_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       set_wen_i,
    input  logic       clr_wen_i,
    input  logic       load_pend_i,
    input  nv_fields_t pend_d_i,
    input  logic       commit_sr_i,
    output logic       wen_o,
    output nv_fields_t nv_o
);
    nv_fields_t pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wen_o  <= 1'b0;
            nv_o   <= '0;
            pend_q <= '0;
        end else begin
            if (set_wen_i)
                wen_o <= 1'b1;
            else if (clr_wen_i)
                wen_o <= 1'b0;
            if (load_pend_i)
                pend_q <= pend_d_i;
            if (commit_sr_i)
                nv_o <= pend_q;
        end
    end
endmodule

// File: rtl/wprot_fsm.sv
module wprot_fsm
    import wprot_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      busy_i,
    input  logic      ev_wren_i,
    input  logic      ev_wrdi_i,
    input  logic      ev_wrsr_i,
    input  logic      ev_write_i,
    input  logic      sr_ok_i,
    input  logic      arr_ok_i,
    output wp_state_e state_o,
    output logic      ready_o,
    output logic      set_wen_o,
    output logic      clr_wen_o,
    output logic      load_pend_o,
    output logic      commit_sr_o
);
    wp_state_e state_q, state_d;
    logic      take;
    logic      start_sr, start_ar;

    always_comb begin
        take     = (state_q == ST_IDLE) && !busy_i;
        start_sr = take && !ev_wren_i && !ev_wrdi_i && ev_wrsr_i && sr_ok_i;
        start_ar = take && !ev_wren_i && !ev_wrdi_i && !ev_wrsr_i
                   && ev_write_i && arr_ok_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_sr)      state_d = ST_SR_WAIT;
                else if (start_ar) state_d = ST_AR_WAIT;
            end
            ST_SR_WAIT: if (busy_i)  state_d = ST_SR_BUSY;
            ST_SR_BUSY: if (!busy_i) state_d = ST_IDLE;
            ST_AR_WAIT: if (busy_i)  state_d = ST_AR_BUSY;
            ST_AR_BUSY: if (!busy_i) state_d = ST_IDLE;
            default:                 state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        ready_o     = take;
        set_wen_o   = take && ev_wren_i;
        load_pend_o = start_sr;
        commit_sr_o = 1'b0;
        clr_wen_o   = take && !ev_wren_i && ev_wrdi_i;
        unique case (state_q)
            ST_SR_BUSY: begin
                commit_sr_o = !busy_i;
                clr_wen_o   = !busy_i;
            end
            ST_AR_BUSY: clr_wen_o = !busy_i;
            default: ;
        endcase
    end

    assign state_o = state_q;
endmodule

// File: rtl/sr_wprot.sv
module sr_wprot
    import wprot_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter bit BIG_ARRAY = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wp_n_i,
    input  logic              busy_i,
    input  logic              ev_wren_i,
    input  logic              ev_wrdi_i,
    input  logic              ev_wrsr_i,
    input  logic              ev_write_i,
    input  logic [7:0]        wrsr_data_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [7:0]        status_o,
    output logic              sr_permit_o,
    output logic              arr_permit_o
);
    wp_state_e  state;
    nv_fields_t nv_q, pend_d;
    logic       wen_q, ready, guarded, hw_lock;
    logic       sr_ok, arr_ok;
    logic       set_wen, clr_wen, load_pend, commit_sr;
    logic [1:0] bp_w;

    assign pend_d  = '{pen: wrsr_data_i[SB_PEN], bp: wrsr_data_i[SB_BPHI:SB_BPLO]};
    assign bp_w    = nv_q.bp;
    assign hw_lock = nv_q.pen && !wp_n_i;
    assign sr_ok   = wen_q && !hw_lock;
    assign arr_ok  = wen_q && !guarded;

    wprot_bp_decode #(.ADDR_W(ADDR_W), .BIG_ARRAY(BIG_ARRAY)) u_dec (
        .bp_i      (nv_q.bp),
        .addr_i    (addr_i),
        .guarded_o (guarded)
    );

    wprot_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .busy_i      (busy_i),
        .ev_wren_i   (ev_wren_i),
        .ev_wrdi_i   (ev_wrdi_i),
        .ev_wrsr_i   (ev_wrsr_i),
        .ev_write_i  (ev_write_i),
        .sr_ok_i     (sr_ok),
        .arr_ok_i    (arr_ok),
        .state_o     (state),
        .ready_o     (ready),
        .set_wen_o   (set_wen),
        .clr_wen_o   (clr_wen),
        .load_pend_o (load_pend),
        .commit_sr_o (commit_sr)
    );

    wprot_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .set_wen_i   (set_wen),
        .clr_wen_i   (clr_wen),
        .load_pend_i (load_pend),
        .pend_d_i    (pend_d),
        .commit_sr_i (commit_sr),
        .wen_o       (wen_q),
        .nv_o        (nv_q)
    );

    always_comb begin
        if (busy_i) begin
            status_o = 8'hFF;
        end else begin
            status_o          = 8'h70;
            status_o[SB_PEN]  = nv_q.pen;
            status_o[SB_BPHI:SB_BPLO] = nv_q.bp;
            status_o[SB_WEN]  = wen_q;
            status_o[SB_RDY]  = (state != ST_IDLE);
        end
        sr_permit_o  = ready && sr_ok;
        arr_permit_o = ready && arr_ok;
    end
endmodule

// File: rtl/sr_wprot_chk.sv
module sr_wprot_chk
    import wprot_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       busy_i,
    input logic       wp_n_i,
    input logic       ev_wren_i,
    input logic [7:0] status_o,
    input logic       sr_permit_o,
    input logic       arr_permit_o,
    input logic       wen_q,
    input logic [1:0] bp_q,
    input wp_state_e  state
);
    a_r2_busy_reads_ones: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |-> (status_o == 8'hFF && !sr_permit_o && !arr_permit_o));

    a_r5_no_permit_without_wen: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_i && !status_o[SB_WEN]) |-> (!sr_permit_o && !arr_permit_o));

    a_r4_wen_set_only_by_wren: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wen_q) |-> $past(ev_wren_i));

    a_r6_full_guard: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_i && status_o[SB_BPHI:SB_BPLO] == 2'b11) |-> !arr_permit_o);

    a_r8_hw_lock_status: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_i && status_o[SB_PEN] && !wp_n_i) |-> !sr_permit_o);

    a_r9_bp_moves_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(bp_q) |-> ($past(state) == ST_SR_BUSY));

    a_r10_no_permit_outside_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |-> (!sr_permit_o && !arr_permit_o));
endmodule

bind sr_wprot sr_wprot_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy_i       (busy_i),
    .wp_n_i       (wp_n_i),
    .ev_wren_i    (ev_wren_i),
    .status_o     (status_o),
    .sr_permit_o  (sr_permit_o),
    .arr_permit_o (arr_permit_o),
    .wen_q        (wen_q),
    .bp_q         (bp_w),
    .state        (state)
);

// File: tb/sr_wprot_tb_top.sv
module sr_wprot_tb_top;
    // ev field: {enable-set, enable-clear, status-write, array-write}
    typedef struct packed {
        logic [3:0]  ev;
        logic        wpn;
        logic        bsy;
        logic [7:0]  d;
        logic [15:0] a;
        logic [7:0]  st;
        logic        srp;
        logic        arp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 35;
    localparam vec_t VEC [0:NV-1] = '{
        '{4'h0,1'b1,1'b0,8'h00,16'h0000,8'h70,1'b0,1'b0,8'd5},  // R5 latch off
        '{4'h8,1'b1,1'b0,8'h00,16'h0000,8'h72,1'b1,1'b1,8'd4},  // R4 set
        '{4'h4,1'b1,1'b0,8'h00,16'h0000,8'h70,1'b0,1'b0,8'd4},  // R4 clear
        '{4'h8,1'b1,1'b0,8'h00,16'h0000,8'h72,1'b1,1'b1,8'd4},
        '{4'h2,1'b1,1'b0,8'hFF,16'h0000,8'h73,1'b0,1'b0,8'd9},  // R9 staged, R1 rdy
        '{4'h0,1'b1,1'b1,8'h00,16'h0000,8'hFF,1'b0,1'b0,8'd2},  // R2
        '{4'h0,1'b1,1'b1,8'h00,16'h0000,8'hFF,1'b0,1'b0,8'd2},
        '{4'h0,1'b1,1'b0,8'h00,16'h0000,8'hFC,1'b0,1'b0,8'd9},  // R9 commit, R1 layout
        '{4'h8,1'b1,1'b0,8'h00,16'h0000,8'hFE,1'b1,1'b0,8'd6},  // R6 full guard
        '{4'h0,1'b0,1'b0,8'h00,16'h0000,8'hFE,1'b0,1'b0,8'd8},  // R8 lock
        '{4'h2,1'b0,1'b0,8'h00,16'h0000,8'hFE,1'b0,1'b0,8'd8},  // R8 ignored
        '{4'h2,1'b1,1'b0,8'h04,16'h0000,8'hFF,1'b0,1'b0,8'd10}, // R10 accept
        '{4'h0,1'b1,1'b1,8'h00,16'h0000,8'hFF,1'b0,1'b0,8'd2},
        '{4'h0,1'b1,1'b0,8'h00,16'h0000,8'h74,1'b0,1'b0,8'd4},  // R4 cleared by done
        '{4'h8,1'b1,1'b0,8'h00,16'h05FF,8'h76,1'b1,1'b1,8'd6},  // R6 quarter edge
        '{4'h0,1'b1,1'b0,8'h00,16'h0600,8'h76,1'b1,1'b0,8'd6},
        '{4'h0,1'b1,1'b0,8'h00,16'h07FF,8'h76,1'b1,1'b0,8'd6},
        '{4'h0,1'b1,1'b0,8'h00,16'hFDFF,8'h76,1'b1,1'b1,8'd11}, // R11 alias
        '{4'h1,1'b1,1'b0,8'h00,16'h0600,8'h76,1'b1,1'b0,8'd7},  // R7 guarded write
        '{4'h1,1'b1,1'b0,8'h00,16'h0100,8'h77,1'b0,1'b0,8'd10}, // R10 array accept
        '{4'h8,1'b1,1'b0,8'h00,16'h0100,8'h77,1'b0,1'b0,8'd10}, // R10 ignored
        '{4'h0,1'b1,1'b1,8'h00,16'h0100,8'hFF,1'b0,1'b0,8'd2},
        '{4'h8,1'b1,1'b1,8'h00,16'h0100,8'hFF,1'b0,1'b0,8'd10},
        '{4'h0,1'b1,1'b0,8'h00,16'h0100,8'h74,1'b0,1'b0,8'd4},
        '{4'h8,1'b1,1'b0,8'h00,16'h03FF,8'h76,1'b1,1'b1,8'd6},
        '{4'h2,1'b1,1'b0,8'h08,16'h03FF,8'h77,1'b0,1'b0,8'd9},
        '{4'h0,1'b1,1'b1,8'h00,16'h03FF,8'hFF,1'b0,1'b0,8'd2},
        '{4'h0,1'b1,1'b0,8'h00,16'h03FF,8'h78,1'b0,1'b0,8'd9},
        '{4'h8,1'b1,1'b0,8'h00,16'h03FF,8'h7A,1'b1,1'b1,8'd6},  // R6 half edge
        '{4'h0,1'b1,1'b0,8'h00,16'h0400,8'h7A,1'b1,1'b0,8'd6},
        '{4'h2,1'b0,1'b0,8'h80,16'h0400,8'h7B,1'b0,1'b0,8'd8},  // R8 pin alone no lock
        '{4'h0,1'b0,1'b1,8'h00,16'h0400,8'hFF,1'b0,1'b0,8'd2},
        '{4'h0,1'b0,1'b0,8'h00,16'h0400,8'hF0,1'b0,1'b0,8'd9},
        '{4'h8,1'b0,1'b0,8'h00,16'h07FF,8'hF2,1'b0,1'b1,8'd8},  // R8 array free
        '{4'h4,1'b0,1'b0,8'h00,16'h07FF,8'hF0,1'b0,1'b0,8'd4}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wp_n = 1'b1, busy = 1'b0;
    logic        e_wren = 1'b0, e_wrdi = 1'b0, e_wrsr = 1'b0, e_write = 1'b0;
    logic [7:0]  data = 8'h00;
    logic [15:0] addr = 16'h0000;
    logic [7:0]  st_b, st_s;
    logic        srp_b, arp_b, srp_s, arp_s;
    int          n_chk = 0, n_bad = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    sr_wprot dut_i (
        .clk(clk), .rst_n(rst_n), .wp_n_i(wp_n), .busy_i(busy),
        .ev_wren_i(e_wren), .ev_wrdi_i(e_wrdi), .ev_wrsr_i(e_wrsr), .ev_write_i(e_write),
        .wrsr_data_i(data), .addr_i(addr),
        .status_o(st_b), .sr_permit_o(srp_b), .arr_permit_o(arp_b)
    );

    sr_wprot #(.BIG_ARRAY(1'b0)) dut_small_i (
        .clk(clk), .rst_n(rst_n), .wp_n_i(wp_n), .busy_i(busy),
        .ev_wren_i(e_wren), .ev_wrdi_i(e_wrdi), .ev_wrsr_i(e_wrsr), .ev_write_i(e_write),
        .wrsr_data_i(data), .addr_i(addr),
        .status_o(st_s), .sr_permit_o(srp_s), .arr_permit_o(arp_s)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input logic [3:0] ev, input logic wpn, input logic bsy,
                        input logic [7:0] d, input logic [15:0] a);
        @(negedge clk);
        {e_wren, e_wrdi, e_wrsr, e_write} = ev;
        wp_n = wpn; busy = bsy; data = d; addr = a;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #1;
        check("R3 reset status", st_b, 8'h70);
        check("R3 reset permits", {6'd0, srp_b, arp_b}, 8'h00);
        @(negedge clk); rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            step(VEC[i].ev, VEC[i].wpn, VEC[i].bsy, VEC[i].d, VEC[i].a);
            check($sformatf("R%0d vec%0d status", VEC[i].req, i), st_b, VEC[i].st);
            check($sformatf("R%0d vec%0d sr_permit", VEC[i].req, i), {7'd0, srp_b}, {7'd0, VEC[i].srp});
            check($sformatf("R%0d vec%0d arr_permit", VEC[i].req, i), {7'd0, arp_b}, {7'd0, VEC[i].arp});
        end

        // R3: reset in the middle of a pending status write
        step(4'h8, 1'b1, 1'b0, 8'h00, 16'h0000);
        step(4'h2, 1'b1, 1'b0, 8'h8C, 16'h0000);
        @(negedge clk); rst_n = 1'b0;
        #1;
        check("R3 reset mid-cycle status", st_b, 8'h70);
        @(negedge clk); rst_n = 1'b1;
        step(4'h0, 1'b1, 1'b1, 8'h00, 16'h0000);
        step(4'h0, 1'b1, 1'b0, 8'h00, 16'h0000);
        check("R3 staged value dropped", st_b, 8'h70);

        // R6: small-array quarter boundary
        step(4'h8, 1'b1, 1'b0, 8'h00, 16'h0000);
        step(4'h2, 1'b1, 1'b0, 8'h04, 16'h0000);
        step(4'h0, 1'b1, 1'b1, 8'h00, 16'h0000);
        step(4'h0, 1'b1, 1'b0, 8'h00, 16'h0000);
        step(4'h8, 1'b1, 1'b0, 8'h00, 16'h02FF);
        check("R6 small 0x2FF", {7'd0, arp_s}, 8'h01);
        check("R6 big 0x2FF", {7'd0, arp_b}, 8'h01);
        step(4'h0, 1'b1, 1'b0, 8'h00, 16'h0300);
        check("R6 small 0x300", {7'd0, arp_s}, 8'h00);
        step(4'h0, 1'b1, 1'b0, 8'h00, 16'h06FF);
        check("R11 small alias 0x6FF", {7'd0, arp_s}, 8'h01);
        check("R6 big 0x6FF", {7'd0, arp_b}, 8'h00);
        check("R1 small status", st_s, 8'h76);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule